// File: doc/BRIEF.md
# Multi-mode 24-bit counter channel

This block is one channel of a general-purpose counter/timer. A host reaches it through a 16-bit word interface with four write addresses and four read addresses. The writes go to a preload low word, a preload high word, a packed mode word and a one-shot command word. The reads return the counter low word, the counter high word and the mode word. The channel holds two 24-bit preload registers and a 24-bit counter. The counter can be clocked by a quadrature encoder at x1, x2 or x4 resolution, or by an internal tick. It can count up or down, and it can be gated by software or by a hardware source. A sticky flag, here called RCAP, drives the `cout` pin.

Three uses come from the mode settings alone. An encoder position counter counts quadrature steps and can reload on an index pulse. A one-shot counts down from PR0 while RCAP is clear and stops itself when RCAP sets. A pulse train alternates between PR0 and PR1 counts on every terminal count.

The host interface has no back-pressure. Every write strobe is taken in the cycle it is presented, and read data is combinational from `rd_addr`. Only a low-word read with `rd_en` high changes state: it captures the counter.

Top module: `ctr24_channel`

## Requirements
- R1: After reset the counter, both preloads, the mode word and RCAP are 0, so the low, high and mode reads return 0 and `cout` is 0.
- R2: Read address 0 returns counter bits 15:0. Address 1 returns counter bits 23:16 in bits 7:0, with bits 15:8 zero. Address 2 returns the mode word. Address 3 returns 0.
- R3: Write address 0 loads preload bits 15:0. Write address 1 loads preload bits 23:16 from data bits 7:0 and ignores data bits 15:8. Mode bit 14 selects the target: 0 selects PR0 and 1 selects PR1. The preload that is not selected is left unchanged.
- R4: A write to address 3 acts as a command word. Bit 15 clears the counter, and it wins over bit 14. Bit 14 loads the counter from PR0. Bit 3 clears RCAP. The bits can be combined in one write.
- R5: With clock source (mode bits 10:9) set to 3 the channel counts every legal quadrature transition (x4). With 1 it counts transitions of A (x2), and with 0 it counts rising edges of A (x1). The phase sequence A,B = 00,10,11,01 counts up and the reverse counts down. A transition in which both phases change is ignored. Counting wraps modulo 2^24.
- R6: With clock source 2 the channel counts once in every cycle in which `tick` is high and the count is enabled.
- R7: When mode bit 12 is 0, the direction comes from the quadrature phase, and the internal clock counts up. When bit 12 is 1, mode bit 11 sets the direction: 0 counts up and 1 counts down.
- R8: Enable control (mode bits 8:7) works as follows: 0 disables counting and 1 enables it. Values 2 and 3 use the hardware source in mode bits 6:5, which is 0 for `hw_gate`, 1 for NOT `hw_gate`, 2 for NOT RCAP and 3 for RCAP.
- R9: A down count that takes the counter from 1 to 0 is a terminal count. With auto-load (mode bits 4:2) not equal to 1, a terminal count sets RCAP.
- R10: With auto-load 1, a terminal count toggles RCAP. If RCAP becomes 1 the counter loads PR1; if it becomes 0 the counter loads PR0. With RCAP starting at 0, RCAP therefore stays low for PR0 counts and high for PR1 counts, and both values must be at least 1.
- R11: With auto-load 4, a rising edge on `enc_idx` loads the counter from PR0 whether or not counting is enabled.
- R12: `cout` equals the selected source XOR mode bit 1. Mode bit 0 selects the source: 0 selects RCAP and 1 selects the count-enable state.
- R13: When mode bit 13 is 0, a low-word read captures all 24 counter bits, and later high-word reads return the captured bits 23:16. When bit 13 is 1, high-word reads return the live counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 preload low, 1 preload high, 2 mode, 3 command |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; a low-word read captures the counter |
| rd_addr | input | 2 | Read address: 0 counter low, 1 counter high, 2 mode, 3 zero |
| rd_data | output | 16 | Combinational read data |
| enc_a | input | 1 | Quadrature phase A, asynchronous |
| enc_b | input | 1 | Quadrature phase B, asynchronous |
| enc_idx | input | 1 | Index input, asynchronous |
| hw_gate | input | 1 | Hardware enable input |
| tick | input | 1 | Internal clock-source enable |
| cout | output | 1 | Counter output |

## Verification
On every cycle the assertions check the following:
- a command that clears or loads the counter does so;
- a disabled counter with no load pending holds its value;
- a terminal count without auto-load leaves RCAP set;
- a transition in which both quadrature phases change never produces a step;
- a high-word read that follows a low-word read returns the captured bits.

The bench scenarios are the only means of showing the rest. These are the x1, x2 and x4 step ratios, the ±1 quadrature sequence including wrap, and the hardware gate mappings. They also cover the one-shot pulse length and the pulse-train duty pattern for several preload pairs, as well as index reload.

// File: rtl/ctr24_pkg.sv
package ctr24_pkg;
  typedef struct packed {
    logic       rsvd;
    logic       psel;
    logic       latch_live;
    logic       dir_sw;
    logic       dir_down;
    logic [1:0] clk_src;
    logic [1:0] en_ctl;
    logic [1:0] hw_src;
    logic [2:0] reload;
    logic       out_pol;
    logic       out_src;
  } mode_t;

  localparam logic [1:0] CLK_X1  = 2'd0;
  localparam logic [1:0] CLK_X2  = 2'd1;
  localparam logic [1:0] CLK_INT = 2'd2;
  localparam logic [1:0] CLK_X4  = 2'd3;
  localparam logic [2:0] RL_ALT  = 3'd1;
  localparam logic [2:0] RL_IDX  = 3'd4;
endpackage

// File: rtl/ctr24_quad.sv
module ctr24_quad #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_a,
  input  logic       enc_b,
  input  logic       enc_idx,
  input  logic [1:0] res,
  output logic       step,
  output logic       up,
  output logic       idx_rise
);
  logic [SYNC-1:0] a_sr, b_sr, i_sr;
  logic a_p, b_p, i_p;
  logic a_s, b_s, i_s;
  logic chg_a, chg_b, legal;

  assign a_s = a_sr[SYNC-1];
  assign b_s = b_sr[SYNC-1];
  assign i_s = i_sr[SYNC-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sr <= '0; b_sr <= '0; i_sr <= '0;
      a_p <= 1'b0; b_p <= 1'b0; i_p <= 1'b0;
    end else begin
      a_sr <= {a_sr[SYNC-2:0], enc_a};
      b_sr <= {b_sr[SYNC-2:0], enc_b};
      i_sr <= {i_sr[SYNC-2:0], enc_idx};
      a_p <= a_s; b_p <= b_s; i_p <= i_s;
    end
  end

  assign chg_a    = a_s ^ a_p;
  assign chg_b    = b_s ^ b_p;
  assign legal    = chg_a ^ chg_b;
  assign up       = a_s ^ b_p;
  assign idx_rise = i_s & ~i_p;

  always_comb begin
    case (res)
      2'd0:    step = legal & chg_a & a_s;
      2'd1:    step = legal & chg_a;
      2'd3:    step = legal;
      default: step = 1'b0;
    endcase
  end

  // R5
  illegal_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_a && chg_b) |-> !step);
endmodule

// File: rtl/ctr24_core.sv
module ctr24_core
  import ctr24_pkg::*;
#(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_t         mode,
  input  logic          q_step,
  input  logic          q_up,
  input  logic          idx_rise,
  input  logic          tick,
  input  logic          hw_gate,
  input  logic          cmd_wr,
  input  logic [15:0]   cmd,
  input  logic [CW-1:0] pr0,
  input  logic [CW-1:0] pr1,
  output logic [CW-1:0] cnt,
  output logic          rcap,
  output logic          en
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic evt, go_up, hw_en, cmd_clr, cmd_ld, idx_ld, tc;

  always_comb begin
    case (mode.hw_src)
      2'd0:    hw_en = hw_gate;
      2'd1:    hw_en = ~hw_gate;
      2'd2:    hw_en = ~rcap;
      default: hw_en = rcap;
    endcase
    case (mode.en_ctl)
      2'd0:    en = 1'b0;
      2'd1:    en = 1'b1;
      default: en = hw_en;
    endcase
  end

  assign evt     = (mode.clk_src == CLK_INT) ? tick : q_step;
  assign go_up   = mode.dir_sw ? ~mode.dir_down
                 : ((mode.clk_src == CLK_INT) ? 1'b1 : q_up);
  assign cmd_clr = cmd_wr & cmd[15];
  assign cmd_ld  = cmd_wr & cmd[14];
  assign idx_ld  = idx_rise & (mode.reload == RL_IDX);
  assign tc      = en & evt & ~go_up & (cnt == ONE) & ~cmd_clr & ~cmd_ld & ~idx_ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cmd_clr) begin
      cnt <= '0;
    end else if (cmd_ld || idx_ld) begin
      cnt <= pr0;
    end else if (tc) begin
      if (mode.reload == RL_ALT) cnt <= rcap ? pr0 : pr1;
      else                       cnt <= '0;
    end else if (en && evt) begin
      cnt <= go_up ? cnt + ONE : cnt - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    rcap <= 1'b0;
    else if (cmd_wr && cmd[3])     rcap <= 1'b0;
    else if (tc)                   rcap <= (mode.reload == RL_ALT) ? ~rcap : 1'b1;
  end

  // R4
  cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr |=> (cnt == '0));
  // R4
  cmd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd[15] && cmd[14]) |=> (cnt == $past(pr0)));
  // R8
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cmd_wr && !idx_ld) |=> $stable(cnt));
  // R9
  tc_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && mode.reload != RL_ALT && !(cmd_wr && cmd[3])) |=> rcap);
endmodule

// File: rtl/ctr24_channel.sv
module ctr24_channel
  import ctr24_pkg::*;
#(
  parameter int CW   = 24,
  parameter int WW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [WW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [1:0]    rd_addr,
  output logic [WW-1:0] rd_data,
  input  logic          enc_a,
  input  logic          enc_b,
  input  logic          enc_idx,
  input  logic          hw_gate,
  input  logic          tick,
  output logic          cout
);
  localparam int HW  = CW - WW;
  localparam int PAD = 2*WW - CW;

  mode_t         mode;
  logic [CW-1:0] pr0, pr1, cnt, hold_q, hi_src;
  logic          rcap, en, q_step, q_up, idx_rise, cmd_wr;

  assign cmd_wr = wr_en && (wr_addr == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0; pr0 <= '0; pr1 <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: if (mode.psel) pr1[WW-1:0] <= wr_data;
              else           pr0[WW-1:0] <= wr_data;
        2'd1: if (mode.psel) pr1[CW-1:WW] <= wr_data[HW-1:0];
              else           pr0[CW-1:WW] <= wr_data[HW-1:0];
        2'd2: mode <= mode_t'(wr_data);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         hold_q <= '0;
    else if (rd_en && rd_addr == 2'd0)  hold_q <= cnt;
  end

  assign hi_src = mode.latch_live ? cnt : hold_q;

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = cnt[WW-1:0];
      2'd1:    rd_data = {{PAD{1'b0}}, hi_src[CW-1:WW]};
      2'd2:    rd_data = mode;
      default: rd_data = '0;
    endcase
  end

  assign cout = (mode.out_src ? en : rcap) ^ mode.out_pol;

  ctr24_quad #(.SYNC(SYNC)) u_quad (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .res(mode.clk_src), .step(q_step), .up(q_up), .idx_rise(idx_rise)
  );

  ctr24_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .q_step(q_step), .q_up(q_up),
    .idx_rise(idx_rise), .tick(tick), .hw_gate(hw_gate), .cmd_wr(cmd_wr),
    .cmd(wr_data), .pr0(pr0), .pr1(pr1), .cnt(cnt), .rcap(rcap), .en(en)
  );

  // R13
  coherent_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en && rd_addr == 2'd0) && rd_en && rd_addr == 2'd1 && !mode.latch_live)
      |-> (rd_data[HW-1:0] == $past(cnt[CW-1:WW])));
endmodule

// File: tb/ctr24_channel_tb.sv
module ctr24_channel_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, enc_a = 0, enc_b = 0, enc_idx = 0, hw_gate = 0, tick = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic cout;
  int checks = 0, errors = 0;
  int ph = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr24_channel u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .enc_a(enc_a), .enc_b(enc_b),
    .enc_idx(enc_idx), .hw_gate(hw_gate), .tick(tick), .cout(cout)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rd_en = 1; rd_addr = a; #1 v = rd_data;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic rd_cnt(output logic [23:0] v);
    logic [15:0] lo, hi;
    rd(2'd0, lo); rd(2'd1, hi);
    v = {hi[7:0], lo};
  endtask

  task automatic set_pr(input logic [23:0] v);
    wr(2'd0, v[15:0]); wr(2'd1, {8'h00, v[23:16]});
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(posedge clk);
    #1 tick = 0;
  endtask

  task automatic qstep(input bit up);
    @(negedge clk);
    ph = up ? (ph + 1) % 4 : (ph + 3) % 4;
    enc_a = (ph == 1 || ph == 2);
    enc_b = (ph == 2 || ph == 3);
    repeat (5) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [23:0] c;
    int hi_cnt;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 / R2 reset state
    rd(2'd0, v); chk("R1 low", v, 0);
    rd(2'd1, v); chk("R1 high", v, 0);
    rd(2'd2, v); chk("R1 mode", v, 0);
    rd(2'd3, v); chk("R2 addr3", v, 0);
    chk("R1 cout", cout, 0);

    // R3 / R4 preload and load
    wr(2'd2, 16'h0000);
    set_pr(24'h123456);
    wr(2'd3, 16'h4000);
    rd(2'd0, v); chk("R2 low word", v, 16'h3456);
    rd(2'd1, v); chk("R2 high word", v, 16'h0012);
    wr(2'd2, 16'h4000);
    rd(2'd2, v); chk("R2 mode read", v, 16'h4000);
    wr(2'd0, 16'h1111); wr(2'd1, 16'hAA77);
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h8000);
    wr(2'd3, 16'h4000);
    rd_cnt(c); chk("R3 PR0 untouched by PR1 write", c, 24'h123456);
    wr(2'd3, 16'hC000);
    rd_cnt(c); chk("R4 clear wins over load", c, 0);

    // R5 quadrature resolution sweep
    for (int r = 0; r < 3; r++) begin
      logic [15:0] md;
      int k;
      md = (r == 0) ? 16'h0080 : (r == 1) ? 16'h0280 : 16'h0680;
      k  = (r == 0) ? 1 : (r == 1) ? 2 : 4;
      for (int n = 4; n <= 12; n += 4) begin
        wr(2'd2, md);
        wr(2'd3, 16'h8000);
        for (int s = 0; s < n; s++) qstep(1);
        rd_cnt(c); chk("R5 resolution up", c, 24'(n * k / 4));
        for (int s = 0; s < n; s++) qstep(0);
        rd_cnt(c); chk("R5 resolution back to zero", c, 0);
      end
    end
    wr(2'd2, 16'h0680); wr(2'd3, 16'h8000);
    qstep(0);
    rd_cnt(c); chk("R5 wrap below zero", c, 24'hFFFFFF);
    wr(2'd3, 16'h8000);
    @(negedge clk); ph = (ph + 2) % 4;
    enc_a = (ph == 1 || ph == 2); enc_b = (ph == 2 || ph == 3);
    repeat (5) @(posedge clk);
    rd_cnt(c); chk("R5 illegal transition ignored", c, 0);

    // R8 enable control 0 blocks quadrature counting
    wr(2'd2, 16'h0600);
    for (int s = 0; s < 4; s++) qstep(1);
    rd_cnt(c); chk("R8 disabled holds", c, 0);

    // R6 / R7 internal tick, software down
    wr(2'd2, 16'h1C80); set_pr(24'd5); wr(2'd3, 16'h4000);
    ticks(3);
    rd_cnt(c); chk("R7 software down", c, 2);
    wr(2'd2, 16'h0480); wr(2'd3, 16'h8000);
    ticks(7);
    rd_cnt(c); chk("R6 internal up", c, 7);

    // R8 hardware gate mappings
    wr(2'd2, 16'h0500); wr(2'd3, 16'h8000);
    hw_gate = 0; ticks(3);
    rd_cnt(c); chk("R8 gate low", c, 0);
    hw_gate = 1; ticks(3);
    rd_cnt(c); chk("R8 gate high", c, 3);
    wr(2'd2, 16'h0520);
    ticks(2);
    rd_cnt(c); chk("R8 inverted gate", c, 3);
    hw_gate = 0;

    // R13 capture on low read
    wr(2'd2, 16'h0480); set_pr(24'h00FFFF); wr(2'd3, 16'h4000);
    @(negedge clk); rd_en = 1; rd_addr = 0; tick = 1; #1 v = rd_data;
    chk("R13 low at capture", v, 16'hFFFF);
    @(negedge clk); tick = 0; rd_addr = 1; #1 v = rd_data;
    chk("R13 high from capture", v, 16'h0000);
    @(posedge clk); #1 rd_en = 0;
    wr(2'd2, 16'h2480);
    rd(2'd1, v); chk("R13 live high", v, 16'h0001);

    // R9 / R12 one-shot sweep
    for (int p = 1; p <= 5; p++) begin
      wr(2'd2, 16'h1D42); set_pr(24'(p));
      @(negedge clk); wr_en = 1; wr_addr = 3; wr_data = 16'h4008;
      @(posedge clk); #1 wr_en = 0;
      hi_cnt = 0;
      @(negedge clk); tick = 1;
      for (int k = 0; k < 10; k++) begin
        if (cout) hi_cnt++;
        @(negedge clk);
      end
      tick = 0;
      chk("R9 one-shot length", 32'(hi_cnt), 32'(p));
      chk("R12 one-shot idle level", cout, 0);
    end

    // R10 pulse train sweep
    for (int t = 0; t < 3; t++) begin
      int p0, p1;
      p0 = (t == 0) ? 1 : (t == 1) ? 3 : 2;
      p1 = (t == 0) ? 1 : (t == 1) ? 5 : 4;
      wr(2'd2, 16'h1C84); set_pr(24'(p0));
      wr(2'd2, 16'h5C84); set_pr(24'(p1));
      wr(2'd2, 16'h1C84);
      @(negedge clk); wr_en = 1; wr_addr = 3; wr_data = 16'h4008;
      @(posedge clk); #1 wr_en = 0;
      @(negedge clk); tick = 1;
      for (int k = 0; k < 2 * (p0 + p1); k++) begin
        #1 chk("R10 pulse train pattern", cout, ((k % (p0 + p1)) >= p0));
        @(negedge clk);
      end
      tick = 0;
    end

    // R11 index reload
    wr(2'd2, 16'h0010); set_pr(24'h000ABC); wr(2'd3, 16'h8000);
    @(negedge clk); enc_idx = 1;
    repeat (3) @(posedge clk);
    #1 enc_idx = 0;
    repeat (4) @(posedge clk);
    rd_cnt(c); chk("R11 index reload", c, 24'h000ABC);

    // R12 enable-state source
    wr(2'd2, 16'h0081); #1 chk("R12 src enable", cout, 1);
    wr(2'd2, 16'h0083); #1 chk("R12 src enable inverted", cout, 0);
    wr(2'd2, 16'h0001); #1 chk("R12 src disabled", cout, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule